// File: doc/BRIEF.md
# Synchronous USART Frame Receiver

This block turns a serial bit stream on `rxd` into received characters when the serial link runs in clocked (synchronous) mode. The bit clock either arrives from outside on `xck_in` (slave) or is produced inside the block and sent out on `xck_out` (master). In both modes the chosen clock passes through a two-flop synchronizer into the system clock domain, where edge detection turns it into a one-cycle sample pulse. The `polarity` input chooses which clock edge samples the line. Data is launched by the far end on the other edge.

The frame shape is set at run time and shared with the transmitter. It has 5 to 9 data bits, an optional even or odd parity bit, and one or two stop bits. A frame starts with a low start bit. The data bits follow least significant first, then the parity bit if it is enabled, then the stop bits. The receiver accepts a new start bit right after the last stop bit. At the end of each frame it presents the character with a one-cycle valid strobe and two error flags. The outputs hold their values until the next frame ends.

The controller is a state machine with five states. S_IDLE waits for a start bit. S_DATA collects data bits. S_PARITY takes the parity bit. S_STOP1 checks the first stop bit and delivers the result. S_STOP2 skips the second stop bit. The transitions are:
- S_IDLE to S_DATA on a low sample.
- S_DATA to S_PARITY, or to S_STOP1 when parity is off, after the last data bit.
- S_PARITY to S_STOP1 on the next sample.
- S_STOP1 to S_STOP2 when two stop bits are set, otherwise to S_IDLE.
- S_STOP2 to S_IDLE on the next sample.

Top module: `usart_sync_rx`

## Requirements
- R1: With `polarity`=0 `rxd` is sampled on the falling edge of the bit clock. With `polarity`=1 it is sampled on the rising edge.
- R2: A frame begins only when a low level is sampled in S_IDLE. A line held high produces no `rx_valid`.
- R3: Data bits are placed least significant bit first. Their count is `data_len`, which takes the values 5 to 9. Any other `data_len` value is treated as 9.
- R4: Bits of `rx_data` at and above the configured length are zero, even when the previous frame was longer.
- R5: `parity_mode` is coded 0 or 1 for no parity, 2 for even and 3 for odd. The parity bit follows the data bits. `parity_err` is 1 when the data bits plus the parity bit give an odd count of ones (even mode) or an even count (odd mode). With parity off the flag is 0.
- R6: `frame_err` is 1 when the first stop bit is sampled low. With `two_stop`=1 the second stop bit is skipped and never raises `frame_err`.
- R7: `rx_valid` pulses high for exactly one system clock after the first stop bit is sampled. `rx_data`, `parity_err` and `frame_err` hold their values until the next pulse.
- R8: A start bit that directly follows the last stop bit, with no idle bit between them, is received as a new frame.
- R9: With `master_en`=1, `xck_out` toggles every HALF_DIV system clocks and `xck_oe` is 1. With `master_en`=0, `xck_oe` is 0 and the bit clock is taken from `xck_in`.
- R10: During reset `rx_valid`, `rx_data`, `parity_err`, `frame_err` and `xck_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1: block generates the bit clock; 0: bit clock comes from `xck_in` |
| polarity | input | 1 | Sampling edge select: 0 falling, 1 rising |
| xck_in | input | 1 | External bit clock used in slave mode |
| rxd | input | 1 | Serial receive line, idle high |
| data_len | input | 4 | Number of data bits, 5 to 9 |
| parity_mode | input | 2 | 0/1 none, 2 even, 3 odd |
| two_stop | input | 1 | 1: frames carry two stop bits |
| xck_out | output | 1 | Generated bit clock in master mode |
| xck_oe | output | 1 | Output enable for the bit clock pin |
| rx_data | output | 9 | Received character, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| parity_err | output | 1 | Parity mismatch on the last frame |
| frame_err | output | 1 | First stop bit of the last frame was low |

## Verification
The hardest case to reach is a start bit that lands on the very next sample after a stop bit. It comes after either S_STOP1 or S_STOP2, so the state machine must return to S_IDLE in time for that edge. The bench sends several frames in a row with no idle bit between them, in both stop-bit settings, and checks that each character arrives intact. It also checks that no stray strobe appears. The wrong-edge sampling fault is exposed by launching each bit three system clocks after the launch edge. A receiver that sampled on the launch edge would then pick up the previous bit.

// File: rtl/usart_rx_pkg.sv
package usart_rx_pkg;
    localparam int MIN_BITS = 5;
    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2
    } rx_state_e;
endpackage

// File: rtl/usrx_clock_front.sv
module usrx_clock_front #(
    parameter int HALF_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic polarity,
    input  logic xck_in,
    input  logic rxd,
    output logic xck_out,
    output logic xck_oe,
    output logic sample,
    output logic rxd_s
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0]          div_cnt;
    logic                   xck_gen;
    logic                   xck_src;
    logic [SYNC_STAGES-1:0] xck_sync;
    logic [SYNC_STAGES-1:0] rxd_sync;
    logic                   xck_prev;
    logic                   xck_last;

    // local bit clock for master mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            xck_gen <= 1'b0;
        end else if (!master_en) begin
            div_cnt <= '0;
            xck_gen <= 1'b0;
        end else if (div_cnt == CW'(HALF_DIV - 1)) begin
            div_cnt <= '0;
            xck_gen <= ~xck_gen;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign xck_src = master_en ? xck_gen : xck_in;
    assign xck_out = xck_gen;
    assign xck_oe  = master_en;

    // clock and data share the same synchronizer depth so they stay aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xck_sync <= '0;
            rxd_sync <= '1;
            xck_prev <= 1'b0;
        end else begin
            xck_sync <= {xck_sync[SYNC_STAGES-2:0], xck_src};
            rxd_sync <= {rxd_sync[SYNC_STAGES-2:0], rxd};
            xck_prev <= xck_sync[SYNC_STAGES-1];
        end
    end

    assign xck_last = xck_sync[SYNC_STAGES-1];
    assign rxd_s    = rxd_sync[SYNC_STAGES-1];
    assign sample   = polarity ? (xck_last & ~xck_prev) : (~xck_last & xck_prev);

    p_sample_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (xck_last == polarity));

    p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !xck_out);
endmodule

// File: rtl/usrx_frame_fsm.sv
module usrx_frame_fsm
    import usart_rx_pkg::*;
#(
    parameter int NBITS = MAX_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample,
    input  logic                       rxd_s,
    input  logic [$clog2(NBITS+1)-1:0] data_len,
    input  logic [1:0]                 parity_mode,
    input  logic                       two_stop,
    output logic [NBITS-1:0]           rx_data,
    output logic                       rx_valid,
    output logic                       parity_err,
    output logic                       frame_err
);
    localparam int LW = $clog2(NBITS + 1);

    rx_state_e      state, state_nx;
    logic [LW-1:0]  bit_cnt;
    logic [LW-1:0]  eff_len;
    logic [NBITS-1:0] shreg;
    logic           par_acc;
    logic           perr_pend;
    logic           par_en;
    logic           last_bit;

    assign eff_len  = (data_len < LW'(MIN_BITS) || data_len > LW'(NBITS)) ? LW'(NBITS) : data_len;
    assign par_en   = parity_mode[1];
    assign last_bit = (bit_cnt == eff_len - LW'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (sample && !rxd_s) state_nx = S_DATA;
            S_DATA:   if (sample && last_bit) state_nx = par_en ? S_PARITY : S_STOP1;
            S_PARITY: if (sample) state_nx = S_STOP1;
            S_STOP1:  if (sample) state_nx = two_stop ? S_STOP2 : S_IDLE;
            S_STOP2:  if (sample) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            perr_pend  <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample) begin
                unique case (state)
                    S_IDLE: if (!rxd_s) begin
                        bit_cnt   <= '0;
                        shreg     <= '0;
                        par_acc   <= 1'b0;
                        perr_pend <= 1'b0;
                    end
                    S_DATA: begin
                        shreg[bit_cnt] <= rxd_s;
                        par_acc        <= par_acc ^ rxd_s;
                        bit_cnt        <= bit_cnt + 1'b1;
                    end
                    S_PARITY: perr_pend <= par_acc ^ rxd_s ^ parity_mode[0];
                    S_STOP1: begin
                        rx_data    <= shreg;
                        parity_err <= perr_pend;
                        frame_err  <= ~rxd_s;
                        rx_valid   <= 1'b1;
                    end
                    S_STOP2: ;
                    default: ;
                endcase
            end
        end
    end

    p_start_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && sample && !rxd_s) |=> (state == S_DATA));

    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> eff_len) == '0));

    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_valid_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(state) == S_STOP1));

    p_stop2_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP2) |=> !rx_valid);
endmodule

// File: rtl/usart_sync_rx.sv
module usart_sync_rx
    import usart_rx_pkg::*;
#(
    parameter int HALF_DIV    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int NBITS       = MAX_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       master_en,
    input  logic                       polarity,
    input  logic                       xck_in,
    input  logic                       rxd,
    input  logic [$clog2(NBITS+1)-1:0] data_len,
    input  logic [1:0]                 parity_mode,
    input  logic                       two_stop,
    output logic                       xck_out,
    output logic                       xck_oe,
    output logic [NBITS-1:0]           rx_data,
    output logic                       rx_valid,
    output logic                       parity_err,
    output logic                       frame_err
);
    logic sample;
    logic rxd_s;

    usrx_clock_front #(
        .HALF_DIV    (HALF_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .polarity  (polarity),
        .xck_in    (xck_in),
        .rxd       (rxd),
        .xck_out   (xck_out),
        .xck_oe    (xck_oe),
        .sample    (sample),
        .rxd_s     (rxd_s)
    );

    usrx_frame_fsm #(
        .NBITS (NBITS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample      (sample),
        .rxd_s       (rxd_s),
        .data_len    (data_len),
        .parity_mode (parity_mode),
        .two_stop    (two_stop),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .parity_err  (parity_err),
        .frame_err   (frame_err)
    );
endmodule

// File: tb/tb_usart_sync_rx.sv
module tb_usart_sync_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 8;
    localparam int XCK_HALF   = 8;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic       polarity = 1'b0;
    logic       xck_in = 1'b0;
    logic       rxd = 1'b1;
    logic [3:0] data_len = 4'd8;
    logic [1:0] parity_mode = 2'd0;
    logic       two_stop = 1'b0;
    logic       xck_out, xck_oe, rx_valid, parity_err, frame_err;
    logic [8:0] rx_data;
    logic       xck_seen;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid  = 0;
    logic [10:0] exp_q[$];
    string cur_req = "R3";

    usart_sync_rx #(.HALF_DIV(HALF_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .polarity(polarity),
        .xck_in(xck_in), .rxd(rxd), .data_len(data_len), .parity_mode(parity_mode),
        .two_stop(two_stop), .xck_out(xck_out), .xck_oe(xck_oe), .rx_data(rx_data),
        .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #3;
        forever begin
            #(XCK_HALF*CLK_PERIOD);
            xck_in = ~xck_in;
        end
    end

    assign xck_seen = master_en ? xck_out : xck_in;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        if (polarity) @(negedge xck_seen);
        else          @(posedge xck_seen);
        #(3*CLK_PERIOD);
        rxd = b;
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b1);
    endtask

    task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_s1, input bit bad_s2);
        int len;
        logic [8:0] m;
        logic p;
        len = (data_len < 5 || data_len > 9) ? 9 : int'(data_len);
        m = d & 9'((1 << len) - 1);
        p = ^m ^ parity_mode[0] ^ bad_par;
        exp_q.push_back({bad_par & parity_mode[1], bad_s1, m});
        drive_bit(1'b0);
        for (int i = 0; i < len; i++) drive_bit(m[i]);
        if (parity_mode[1]) drive_bit(p);
        drive_bit(~bad_s1);
        if (two_stop) drive_bit(~bad_s2);
    endtask

    task automatic drain(input string req);
        idle_bits(3);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // scoreboard monitor
    logic       hold_pend = 1'b0;
    logic [10:0] held;
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            n_valid++;
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected valid"}, {parity_err, frame_err, rx_data}, 0);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                check({parity_err, frame_err, rx_data} == e, cur_req, {parity_err, frame_err, rx_data}, e);
            end
            held = {parity_err, frame_err, rx_data};
            hold_pend = 1'b1;
        end else if (hold_pend) begin
            hold_pend = 1'b0;
            // R7: strobe one cycle wide, outputs held
            check({parity_err, frame_err, rx_data} == held, "R7 hold", {parity_err, frame_err, rx_data}, held);
        end
    end

    initial begin
        #(WD_CYCLES*CLK_PERIOD);
        n_fails++;
        $display("FAIL R8 watchdog expired: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int cnt0;
        time t1, t2;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check({rx_valid, parity_err, frame_err, rx_data, xck_oe} == '0, "R10", {rx_valid, parity_err, frame_err, rx_data, xck_oe}, 0);
        rst_n = 1'b1;
        idle_bits(2);

        // R2: idle line produces nothing
        cnt0 = n_valid;
        idle_bits(10);
        check(n_valid == cnt0, "R2", n_valid, cnt0);

        // R3, R1 polarity 0
        cur_req = "R1 R3 pol0";
        send_frame(9'h0A5, 0, 0, 0);
        send_frame(9'h05A, 0, 0, 0);
        drain("R1");

        // R1 polarity 1
        polarity = 1'b1; idle_bits(2);
        cur_req = "R1 pol1";
        send_frame(9'h03C, 0, 0, 0);
        send_frame(9'h0C3, 0, 0, 0);
        drain("R1");
        polarity = 1'b0; idle_bits(2);

        // R3 nine bits, then R4 short frame after long
        data_len = 4'd9; cur_req = "R3 nine";
        send_frame(9'h1FF, 0, 0, 0);
        send_frame(9'h155, 0, 0, 0);
        drain("R3");
        data_len = 4'd5; cur_req = "R4 upper zero";
        send_frame(9'h1FF, 0, 0, 0);
        drain("R4");
        data_len = 4'd3; cur_req = "R3 out of range";
        send_frame(9'h12B, 0, 0, 0);
        drain("R3");

        // R5 parity
        data_len = 4'd8;
        parity_mode = 2'd2; cur_req = "R5 even";
        send_frame(9'h0B7, 0, 0, 0);
        send_frame(9'h0B7, 1, 0, 0);
        parity_mode = 2'd3; cur_req = "R5 odd";
        send_frame(9'h0B7, 0, 0, 0);
        send_frame(9'h041, 1, 0, 0);
        drain("R5");
        parity_mode = 2'd0;

        // R6 frame error and ignored second stop
        cur_req = "R6 stop1";
        send_frame(9'h077, 0, 1, 0);
        idle_bits(1);
        two_stop = 1'b1; cur_req = "R6 stop2 ignored";
        send_frame(9'h088, 0, 0, 1);
        drain("R6");

        // R8 back-to-back frames, two stops then one stop
        data_len = 4'd7; cur_req = "R8 two stop";
        send_frame(9'h055, 0, 0, 0);
        send_frame(9'h02A, 0, 0, 0);
        send_frame(9'h07F, 0, 0, 0);
        drain("R8");
        two_stop = 1'b0; parity_mode = 2'd2; cur_req = "R8 one stop";
        send_frame(9'h001, 0, 0, 0);
        send_frame(9'h040, 1, 0, 0);
        send_frame(9'h000, 0, 0, 0);
        drain("R8");
        parity_mode = 2'd0; data_len = 4'd8;

        // R9 slave mode oe
        @(negedge clk);
        check(xck_oe == 1'b0, "R9 slave oe", xck_oe, 0);

        // R9 master mode
        master_en = 1'b1;
        @(posedge xck_out); t1 = $time;
        @(negedge xck_out); t2 = $time;
        check((t2 - t1) == HALF_DIV*CLK_PERIOD, "R9 period", 32'(t2 - t1), HALF_DIV*CLK_PERIOD);
        @(negedge clk);
        check(xck_oe == 1'b1, "R9 master oe", xck_oe, 1);
        idle_bits(2);
        cur_req = "R9 master pol0";
        send_frame(9'h0E1, 0, 0, 0);
        drain("R9");
        polarity = 1'b1; idle_bits(2);
        cur_req = "R9 master pol1";
        send_frame(9'h01E, 0, 0, 0);
        drain("R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule